// File: doc/BRIEF.md
# Dual-Pointer XY Address Generator

This block forms word addresses for two parallel 16-bit data memories, called X and Y, so that one X transfer and one Y transfer can be issued in the same clock cycle. It keeps a small register file with two X pointers, two Y pointers, one X index and one Y index. All registers are 32 bits wide. Every address is taken from a pointer register; there is no immediate offset.

Each cycle the block can take one request for X and one for Y. A request carries an enable, a pointer select and an addressing mode. For each granted request the block registers a 15-bit word address, which is pointer bits 15:1, together with a valid strobe. At the same clock edge it writes back the post-modified pointer. The pointer can be left as it is, stepped by +2, or moved by the index register of its own bank. Only the lower 16 bits of a pointer take part in addressing and are rewritten on update. Bit 0 is dropped from the address, and software keeps bit 0 of pointers and indexes at zero.

A write port loads whole 32-bit register values. A registered read port returns them, so the upper-half retention can be observed.

Top module: `xy_agu`

## Requirements
- R1: After synchronous reset, every register reads 0 through the read port, and `x_vld` and `y_vld` are low.
- R2: When `x_en` is high at a clock edge, `x_vld` is high after that edge and `x_addr` equals bits 15:1 of the selected X pointer (`x_sel` 0 or 1), taken before its update. The Y side behaves the same way with `y_en`, `y_sel` and `y_addr`. Both sides can be active in the same cycle.
- R3: The address ignores pointer bit 0 and pointer bits 31:16.
- R4: Mode code 2'b00 (keep) leaves the pointer unchanged.
- R5: Mode code 2'b01 (step) adds 2 to the lower 16 bits of the selected pointer, modulo 2^16.
- R6: Mode code 2'b10 (index) adds the lower 16 bits of the same bank's index register to the lower 16 bits of the pointer, modulo 2^16. An index of 0xFFFE therefore steps the pointer down by 2. The X index never changes a Y pointer, and the Y index never changes an X pointer.
- R7: On any update, pointer bits 31:16 keep their previous value, and no carry passes out of bit 15.
- R8: The write and read codes are: 0 = X pointer 0, 1 = X pointer 1, 2 = Y pointer 0, 3 = Y pointer 1, 4 = X index, 6 = Y index. Codes 5 and 7 are ignored on write and read as 0. `rd_data` shows the value of the register named by `rd_sel` as it stood before the clock edge, and appears one edge later.
- R9: When a write and a post-update hit the same pointer in the same cycle, the post-update wins. It is computed from the pointer's old value.
- R10: Mode code 2'b11 behaves as keep. When the enable is low, the pointer is not touched and the valid strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| x_en | input | 1 | X request enable |
| x_sel | input | 1 | X pointer select |
| x_mode | input | 2 | X post-modify mode |
| y_en | input | 1 | Y request enable |
| y_sel | input | 1 | Y pointer select |
| y_mode | input | 2 | Y post-modify mode |
| wr_en | input | 1 | Register write enable |
| wr_sel | input | 3 | Register write code |
| wr_data | input | 32 | Register write value |
| rd_sel | input | 3 | Register read code |
| rd_data | output | 32 | Registered read value |
| x_vld | output | 1 | X address valid |
| x_addr | output | 15 | X word address |
| y_vld | output | 1 | Y address valid |
| y_addr | output | 15 | Y word address |

## Verification
The address outputs, the valid strobes and the read data are all registered. Each one is due at the first clock edge after the inputs that caused it. A pointer change becomes visible on `rd_data` one further edge later, through a read issued in the next cycle.

The bench drives each cycle's inputs at the falling edge and pushes the expected results for that cycle into a queue. The monitor pops that item 2 ns after the following rising edge, so every comparison falls exactly one register stage after its stimulus. The expected results come from a register model that the bench updates with write-then-post-update priority.

// File: rtl/xy_agu_pkg.sv
package xy_agu_pkg;

  // Post-modify modes; the reserved code acts as keep.
  typedef enum logic [1:0] {
    AM_KEEP  = 2'b00,
    AM_STEP  = 2'b01,
    AM_INDEX = 2'b10,
    AM_RSVD  = 2'b11
  } am_e;

endpackage

// File: rtl/xy_agu_step.sv
module xy_agu_step #(
  parameter int AW = 16
) (
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] idx,
  input  logic [1:0]    mode,
  output logic [AW-1:0] nxt,
  output logic          upd
);
  import xy_agu_pkg::*;

  localparam logic [AW-1:0] WORD_STEP = AW'(2);

  always_comb begin
    nxt = base;
    upd = 1'b0;
    case (am_e'(mode))
      AM_STEP: begin
        nxt = base + WORD_STEP;
        upd = 1'b1;
      end
      AM_INDEX: begin
        nxt = base + idx;
        upd = 1'b1;
      end
      default: begin
        nxt = base;
        upd = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/xy_agu_bank.sv
module xy_agu_bank #(
  parameter int RW   = 32,
  parameter int AW   = 16,
  parameter int NPTR = 2,
  parameter int PSW  = (NPTR > 1) ? $clog2(NPTR) : 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      req_en,
  input  logic [PSW-1:0]            req_sel,
  input  logic [1:0]                req_mode,
  input  logic [NPTR-1:0]           wr_ptr_en,
  input  logic                      wr_idx_en,
  input  logic [RW-1:0]             wr_data,
  output logic [NPTR-1:0][RW-1:0]   ptrs,
  output logic [RW-1:0]             idx_q,
  output logic [AW-2:0]             addr_q,
  output logic                      vld_q
);

  logic [RW-1:0] ptr_q [NPTR];
  logic [AW-1:0] cur_lo;
  logic [AW-1:0] nxt_lo;
  logic          upd;

  assign cur_lo = ptr_q[req_sel][AW-1:0];

  xy_agu_step #(.AW(AW)) u_step (
    .base (cur_lo),
    .idx  (idx_q[AW-1:0]),
    .mode (req_mode),
    .nxt  (nxt_lo),
    .upd  (upd)
  );

  for (genvar p = 0; p < NPTR; p++) begin : g_ptr
    always_ff @(posedge clk) begin
      if (rst) begin
        ptr_q[p] <= '0;
      end else if (req_en && (req_sel == PSW'(p)) && upd) begin
        ptr_q[p] <= {ptr_q[p][RW-1:AW], nxt_lo};
      end else if (wr_ptr_en[p]) begin
        ptr_q[p] <= wr_data;
      end
    end
    assign ptrs[p] = ptr_q[p];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q <= '0;
    end else if (wr_idx_en) begin
      idx_q <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q  <= 1'b0;
      addr_q <= '0;
    end else begin
      vld_q <= req_en;
      if (req_en) begin
        addr_q <= cur_lo[AW-1:1];
      end
    end
  end

endmodule

// File: rtl/xy_agu.sv
module xy_agu #(
  parameter int RW   = 32,
  parameter int AW   = 16,
  parameter int NPTR = 2,
  localparam int PSW = (NPTR > 1) ? $clog2(NPTR) : 1,
  localparam int SW  = PSW + 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           x_en,
  input  logic [PSW-1:0] x_sel,
  input  logic [1:0]     x_mode,
  input  logic           y_en,
  input  logic [PSW-1:0] y_sel,
  input  logic [1:0]     y_mode,
  input  logic           wr_en,
  input  logic [SW-1:0]  wr_sel,
  input  logic [RW-1:0]  wr_data,
  input  logic [SW-1:0]  rd_sel,
  output logic [RW-1:0]  rd_data,
  output logic           x_vld,
  output logic [AW-2:0]  x_addr,
  output logic           y_vld,
  output logic [AW-2:0]  y_addr
);

  localparam int NB = 2;  // bank 0 = X, bank 1 = Y

  logic [NB-1:0]                   b_en;
  logic [NB-1:0][PSW-1:0]          b_sel;
  logic [NB-1:0][1:0]              b_mode;
  logic [NB-1:0][NPTR-1:0]         b_wr_ptr;
  logic [NB-1:0]                   b_wr_idx;
  logic [NB-1:0][NPTR-1:0][RW-1:0] b_ptrs;
  logic [NB-1:0][RW-1:0]           b_idx;
  logic [NB-1:0][AW-2:0]           b_addr;
  logic [NB-1:0]                   b_vld;

  // Code layout: {kind, bank, pointer}; kind 1 is the bank index when pointer field is 0.
  logic           wr_kind, rd_kind;
  logic           wr_bank, rd_bank;
  logic [PSW-1:0] wr_ptr,  rd_ptr;
  logic [RW-1:0]  rd_val;

  assign wr_kind = wr_sel[SW-1];
  assign wr_bank = wr_sel[PSW];
  assign wr_ptr  = wr_sel[PSW-1:0];
  assign rd_kind = rd_sel[SW-1];
  assign rd_bank = rd_sel[PSW];
  assign rd_ptr  = rd_sel[PSW-1:0];

  assign b_en   = {y_en, x_en};
  assign b_sel  = {y_sel, x_sel};
  assign b_mode = {y_mode, x_mode};

  for (genvar b = 0; b < NB; b++) begin : g_bank
    assign b_wr_idx[b] = wr_en && wr_kind && (wr_bank == 1'(b)) && (wr_ptr == '0);
    for (genvar p = 0; p < NPTR; p++) begin : g_wsel
      assign b_wr_ptr[b][p] = wr_en && !wr_kind && (wr_bank == 1'(b)) && (wr_ptr == PSW'(p));
    end

    xy_agu_bank #(
      .RW(RW), .AW(AW), .NPTR(NPTR), .PSW(PSW)
    ) u_bank (
      .clk       (clk),
      .rst       (rst),
      .req_en    (b_en[b]),
      .req_sel   (b_sel[b]),
      .req_mode  (b_mode[b]),
      .wr_ptr_en (b_wr_ptr[b]),
      .wr_idx_en (b_wr_idx[b]),
      .wr_data   (wr_data),
      .ptrs      (b_ptrs[b]),
      .idx_q     (b_idx[b]),
      .addr_q    (b_addr[b]),
      .vld_q     (b_vld[b])
    );
  end

  always_comb begin
    if (rd_kind) begin
      rd_val = (rd_ptr == '0) ? b_idx[rd_bank] : '0;
    end else begin
      rd_val = b_ptrs[rd_bank][rd_ptr];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      rd_data <= rd_val;
    end
  end

  assign x_vld  = b_vld[0];
  assign x_addr = b_addr[0];
  assign y_vld  = b_vld[1];
  assign y_addr = b_addr[1];

endmodule

// File: rtl/xy_agu_chk.sv
module xy_agu_chk #(
  parameter int RW   = 32,
  parameter int AW   = 16,
  parameter int NPTR = 2,
  localparam int PSW = (NPTR > 1) ? $clog2(NPTR) : 1
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    x_en,
  input logic [PSW-1:0]          x_sel,
  input logic [1:0]              x_mode,
  input logic                    y_en,
  input logic [PSW-1:0]          y_sel,
  input logic [1:0]              y_mode,
  input logic                    wr_en,
  input logic                    x_vld,
  input logic [AW-2:0]           x_addr,
  input logic                    y_vld,
  input logic [AW-2:0]           y_addr,
  input logic [NPTR-1:0][RW-1:0] x_ptrs,
  input logic [NPTR-1:0][RW-1:0] y_ptrs
);

  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!x_vld && !y_vld));

  assert_x_vld_R2: assert property (@(posedge clk) disable iff (rst)
    x_en |=> x_vld);
  assert_y_vld_R2: assert property (@(posedge clk) disable iff (rst)
    y_en |=> y_vld);
  assert_x_idle_R10: assert property (@(posedge clk) disable iff (rst)
    !x_en |=> !x_vld);
  assert_y_idle_R10: assert property (@(posedge clk) disable iff (rst)
    !y_en |=> !y_vld);

  for (genvar p = 0; p < NPTR; p++) begin : g_p
    assert_x_addr_R2: assert property (@(posedge clk) disable iff (rst)
      (x_en && x_sel == PSW'(p)) |=> x_addr == $past(x_ptrs[p][AW-1:1]));
    assert_y_addr_R2: assert property (@(posedge clk) disable iff (rst)
      (y_en && y_sel == PSW'(p)) |=> y_addr == $past(y_ptrs[p][AW-1:1]));
    assert_x_keep_R4: assert property (@(posedge clk) disable iff (rst)
      (x_en && x_sel == PSW'(p) && x_mode == 2'b00 && !wr_en) |=> $stable(x_ptrs[p]));
    assert_y_keep_R4: assert property (@(posedge clk) disable iff (rst)
      (y_en && y_sel == PSW'(p) && y_mode == 2'b00 && !wr_en) |=> $stable(y_ptrs[p]));
    assert_x_step_R5: assert property (@(posedge clk) disable iff (rst)
      (x_en && x_sel == PSW'(p) && x_mode == 2'b01)
        |=> x_ptrs[p][AW-1:0] == AW'($past(x_ptrs[p][AW-1:0]) + AW'(2)));
    assert_y_step_R5: assert property (@(posedge clk) disable iff (rst)
      (y_en && y_sel == PSW'(p) && y_mode == 2'b01)
        |=> y_ptrs[p][AW-1:0] == AW'($past(y_ptrs[p][AW-1:0]) + AW'(2)));
    assert_x_upper_R7: assert property (@(posedge clk) disable iff (rst)
      (x_en && x_sel == PSW'(p) && !wr_en) |=> x_ptrs[p][RW-1:AW] == $past(x_ptrs[p][RW-1:AW]));
    assert_y_upper_R7: assert property (@(posedge clk) disable iff (rst)
      (y_en && y_sel == PSW'(p) && !wr_en) |=> y_ptrs[p][RW-1:AW] == $past(y_ptrs[p][RW-1:AW]));
  end

endmodule

bind xy_agu xy_agu_chk #(.RW(RW), .AW(AW), .NPTR(NPTR)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .x_en   (x_en),
  .x_sel  (x_sel),
  .x_mode (x_mode),
  .y_en   (y_en),
  .y_sel  (y_sel),
  .y_mode (y_mode),
  .wr_en  (wr_en),
  .x_vld  (x_vld),
  .x_addr (x_addr),
  .y_vld  (y_vld),
  .y_addr (y_addr),
  .x_ptrs (b_ptrs[0]),
  .y_ptrs (b_ptrs[1])
);

// File: tb/test_xy_agu.sv
`timescale 1ns/1ps
module test_xy_agu;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        x_en = 0, y_en = 0, wr_en = 0;
  logic        x_sel = 0, y_sel = 0;
  logic [1:0]  x_mode = 0, y_mode = 0;
  logic [2:0]  wr_sel = 0, rd_sel = 0;
  logic [31:0] wr_data = 0;
  logic [31:0] rd_data;
  logic        x_vld, y_vld;
  logic [14:0] x_addr, y_addr;

  always #4 clk = ~clk;

  xy_agu i_xy_agu (
    .clk(clk), .rst(rst),
    .x_en(x_en), .x_sel(x_sel), .x_mode(x_mode),
    .y_en(y_en), .y_sel(y_sel), .y_mode(y_mode),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data),
    .x_vld(x_vld), .x_addr(x_addr), .y_vld(y_vld), .y_addr(y_addr)
  );

  typedef struct {
    logic        xv;
    logic [14:0] xa;
    logic        yv;
    logic [14:0] ya;
    logic [31:0] rd;
    string       tag;
  } exp_t;

  exp_t        q[$];
  logic [31:0] m [8];
  int          checks = 0;
  int          errors = 0;
  bit          done = 0;

  task automatic chk(input logic ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, expv);
    end
  endtask

  // Monitor: results are due one edge after the falling edge that drove them.
  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk(x_vld == e.xv, e.tag, "x_vld", 32'(x_vld), 32'(e.xv));
      chk(y_vld == e.yv, e.tag, "y_vld", 32'(y_vld), 32'(e.yv));
      if (e.xv) chk(x_addr == e.xa, e.tag, "x_addr", 32'(x_addr), 32'(e.xa));
      if (e.yv) chk(y_addr == e.ya, e.tag, "y_addr", 32'(y_addr), 32'(e.ya));
      chk(rd_data == e.rd, e.tag, "rd_data", rd_data, e.rd);
    end
  end

  task automatic step(input logic xe, input logic xs, input logic [1:0] xm,
                      input logic ye, input logic ys, input logic [1:0] ym,
                      input logic we, input logic [2:0] ws, input logic [31:0] wd,
                      input logic [2:0] rs, input string tag);
    exp_t        e;
    logic [31:0] nm [8];
    logic [15:0] lo;
    int          xi, yi;
    @(negedge clk);
    x_en = xe; x_sel = xs; x_mode = xm;
    y_en = ye; y_sel = ys; y_mode = ym;
    wr_en = we; wr_sel = ws; wr_data = wd; rd_sel = rs;
    xi = int'(xs);
    yi = 2 + int'(ys);
    e.xv = xe; e.xa = m[xi][15:1];
    e.yv = ye; e.ya = m[yi][15:1];
    e.rd = m[rs];
    e.tag = tag;
    q.push_back(e);
    nm = m;
    if (we && ws != 3'd5 && ws != 3'd7) nm[ws] = wd;
    if (xe && (xm == 2'b01 || xm == 2'b10)) begin
      lo = m[xi][15:0] + ((xm == 2'b01) ? 16'd2 : m[4][15:0]);
      nm[xi] = {m[xi][31:16], lo};
    end
    if (ye && (ym == 2'b01 || ym == 2'b10)) begin
      lo = m[yi][15:0] + ((ym == 2'b01) ? 16'd2 : m[6][15:0]);
      nm[yi] = {m[yi][31:16], lo};
    end
    m = nm;
  endtask

  task automatic idle(input logic [2:0] rs, input string tag);
    step(0, 0, 2'b00, 0, 0, 2'b00, 0, 3'd0, 32'd0, rs, tag);
  endtask

  task automatic wreg(input logic [2:0] ws, input logic [31:0] wd, input string tag);
    step(0, 0, 2'b00, 0, 0, 2'b00, 1, ws, wd, 3'd0, tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired: actual=running expected=finished");
    finish_run();
  end

  initial begin
    foreach (m[i]) m[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: every code reads zero, no valid strobes
    for (int i = 0; i < 8; i++) idle(3'(i), "R1_reset");

    // R8: load registers, write to unused codes ignored
    wreg(3'd0, 32'hABCD_1230, "R8_wr");
    wreg(3'd1, 32'h0000_0100, "R8_wr");
    wreg(3'd2, 32'h5555_FFFE, "R8_wr");
    wreg(3'd3, 32'h1234_0011, "R8_wr");
    wreg(3'd4, 32'h0000_0006, "R8_wr");
    wreg(3'd6, 32'hFFFF_FFFE, "R8_wr");
    wreg(3'd5, 32'hDEAD_BEEF, "R8_wr");
    wreg(3'd7, 32'hCAFE_F00D, "R8_wr");
    for (int i = 0; i < 8; i++) idle(3'(i), "R8_readback");

    // R2 R4: simultaneous keep on X0 and Y1; R3: Y1 has bit 0 and upper bits set
    step(1, 0, 2'b00, 1, 1, 2'b00, 0, 3'd0, 32'd0, 3'd0, "R2_R3_R4_keep");
    step(1, 0, 2'b00, 1, 1, 2'b00, 0, 3'd0, 32'd0, 3'd3, "R2_R4_keep_again");
    idle(3'd0, "R4_readback");

    // R5: step X1 several times, Y0 wraps from 0xFFFE to 0 (R7)
    step(1, 1, 2'b01, 1, 0, 2'b01, 0, 3'd0, 32'd0, 3'd0, "R5_step");
    step(1, 1, 2'b01, 0, 0, 2'b00, 0, 3'd0, 32'd0, 3'd1, "R5_step");
    step(1, 1, 2'b01, 1, 0, 2'b01, 0, 3'd0, 32'd0, 3'd2, "R5_R7_wrap");
    idle(3'd1, "R5_readback");
    idle(3'd2, "R7_readback");

    // R6: X0 moves by X index, Y1 moves by Y index (-2), upper halves kept (R7)
    step(1, 0, 2'b10, 1, 1, 2'b10, 0, 3'd0, 32'd0, 3'd0, "R6_index");
    step(1, 0, 2'b10, 1, 1, 2'b10, 0, 3'd0, 32'd0, 3'd0, "R6_index");
    idle(3'd3, "R6_R7_readback");
    idle(3'd1, "R6_other_ptr");

    // R7: X index wraps the lower half of X1 with no carry upward
    wreg(3'd1, 32'h7777_FFFC, "R7_load");
    wreg(3'd4, 32'h0000_0008, "R7_load");
    step(1, 1, 2'b10, 0, 0, 2'b00, 0, 3'd0, 32'd0, 3'd1, "R7_idx_wrap");
    idle(3'd1, "R7_readback");

    // R9: write and post-update on same pointer: post-update wins
    step(1, 1, 2'b01, 0, 0, 2'b00, 1, 3'd1, 32'hDEAD_0000, 3'd1, "R9_collide");
    idle(3'd1, "R9_readback");
    step(0, 0, 2'b00, 1, 0, 2'b10, 1, 3'd2, 32'h0BAD_0BAD, 3'd2, "R9_collide_y");
    idle(3'd2, "R9_readback_y");
    // Write to a different pointer in the same cycle still lands
    step(1, 0, 2'b01, 0, 0, 2'b00, 1, 3'd1, 32'h0000_0040, 3'd0, "R9_other");
    idle(3'd1, "R9_other_readback");

    // R10: reserved mode keeps pointer; disabled request with step mode does nothing
    step(1, 0, 2'b11, 1, 1, 2'b11, 0, 3'd0, 32'd0, 3'd0, "R10_rsvd");
    step(0, 0, 2'b01, 0, 1, 2'b10, 0, 3'd0, 32'd0, 3'd0, "R10_disabled");
    idle(3'd3, "R10_readback");
    idle(3'd0, "R10_readback");

    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule